// File: doc/BRIEF.md
# ADC Output Formatter with Test Patterns

This block sits between a 14-bit converter core and the output pins of a data converter. Each accepted sample, a signed two's complement word, has a signed offset added to it, and the sum is clamped to the 14-bit signed range. A test pattern may take the place of that stream. The choices are all-zeros, all-ones, an alternating bit pattern, an incrementing ramp, or a word written by the user. The pattern is chosen after the offset has been applied, so a pattern never carries an offset.

The result is held in one output register. The pins present it in one of two ways. In single-rate parallel mode all 14 bits appear at once. In double-rate mode seven lanes each carry two adjacent bits, one per clock phase. A data-valid output toggles once for every accepted sample so that a receiver can capture the data.

Samples enter through a valid/ready port. The pins cannot apply back-pressure, so `in_ready` is held high at all times. A sample is accepted on every rising edge where `in_valid` is high. When `in_valid` is low, nothing is consumed and the outputs hold their last word. The control inputs (`pat_sel`, `pat_user`, `in_offset`, `ddr_mode`) are plain levels. They are sampled together with each accepted sample.

Top module: `adc_out_formatter`

## Requirements
- R1: With pattern code 000 and offset 0, the output word equals the accepted sample, one rising edge after acceptance.
- R2: The 6-bit offset is a signed value from -32 to +31 and is added to the signed sample. The sum saturates at -8192 (0x2000) and +8191 (0x1FFF) instead of wrapping.
- R3: Pattern code 001 outputs 0x0000 and code 010 outputs 0x3FFF.
- R4: Pattern code 011 outputs 0x1555 on the first accepted sample and 0x2AAA on the next, alternating from then on. An accepted sample with any other code resets it so that it starts again at 0x1555.
- R5: Pattern code 100 outputs a ramp that starts at 0, rises by 1 per accepted sample and wraps from 0x3FFF to 0. An accepted sample with any other code resets it to 0.
- R6: Pattern code 101 outputs the user word. Under codes 001 to 101 the sample and the offset have no effect on the output.
- R7: Pattern codes 110 and 111 behave exactly like code 000.
- R8: With `ddr_mode`=0, `out_pins[13:0]` carry the output word.
- R9: With `ddr_mode`=1, lane i (`out_pins[i]`, i=0..6) carries word bit 2i while `clk` is high and bit 2i+1 while `clk` is low. `out_pins[13:7]` are 0.
- R10: After reset the output word and `out_dav` are 0. `out_dav` inverts on every edge that accepts a sample. With no accepted sample, both the word and `out_dav` hold.
- R11: `in_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_ready | output | 1 | Always high; the block never stalls |
| in_sample | input | 14 | Signed converter sample |
| in_offset | input | 6 | Signed digital offset |
| pat_sel | input | 3 | Pattern code (000 normal, 001 zeros, 010 ones, 011 alternating, 100 ramp, 101 user, 110/111 normal) |
| pat_user | input | 14 | User pattern word |
| ddr_mode | input | 1 | 0 single-rate parallel, 1 double-rate lanes |
| out_pins | output | 14 | Formatted output pins |
| out_dav | output | 1 | Data-valid toggle |

## Verification
Every result appears at the first rising edge after the one that accepts the sample. This applies to the word, the pattern state and `out_dav`. The bench drives its inputs 4 ns before a rising edge and then checks the pins twice. The first check is 5 ns after the edge, in the clock-high phase, and the second is 15 ns after, in the low phase. These two instants give the even and odd bits of each double-rate lane. The mode selection is combinational, so both mappings are checked against the same registered word. Cycles with `in_valid` low are spread through the sweeps. On those cycles the bench expects the word and `out_dav` to be unchanged.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  localparam int SELW = 3;
  localparam logic [SELW-1:0] PAT_NORMAL = 3'd0;
  localparam logic [SELW-1:0] PAT_ZEROS  = 3'd1;
  localparam logic [SELW-1:0] PAT_ONES   = 3'd2;
  localparam logic [SELW-1:0] PAT_ALT    = 3'd3;
  localparam logic [SELW-1:0] PAT_RAMP   = 3'd4;
  localparam logic [SELW-1:0] PAT_USER   = 3'd5;
endpackage

// File: rtl/fmt_offset_sat.sv
module fmt_offset_sat #(
  parameter int DW = 14,
  parameter int OW = 6
) (
  input  logic [DW-1:0] sample,
  input  logic [OW-1:0] offset,
  output logic [DW-1:0] sum
);
  localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic [DW:0] wide;

  always_comb begin
    wide = {sample[DW-1], sample} + {{(DW+1-OW){offset[OW-1]}}, offset};
    if (wide[DW] != wide[DW-1])
      sum = wide[DW] ? MINV : MAXV;
    else
      sum = wide[DW-1:0];
  end
endmodule

// File: rtl/fmt_pattern_gen.sv
module fmt_pattern_gen
  import adc_fmt_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [SELW-1:0] sel,
  input  logic [DW-1:0]   user_word,
  output logic [DW-1:0]   pat_word,
  output logic            pat_active
);
  logic [DW-1:0] even_mask;
  logic [DW-1:0] odd_mask;
  logic          alt_ph;
  logic [DW-1:0] ramp_q;

  for (genvar b = 0; b < DW; b++) begin : g_mask
    assign even_mask[b] = (b % 2 == 0);
    assign odd_mask[b]  = (b % 2 == 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_ph <= 1'b0;
      ramp_q <= '0;
    end else if (adv) begin
      alt_ph <= (sel == PAT_ALT)  ? ~alt_ph : 1'b0;
      ramp_q <= (sel == PAT_RAMP) ? ramp_q + 1'b1 : '0;
    end
  end

  always_comb begin
    pat_active = 1'b1;
    unique case (sel)
      PAT_ZEROS: pat_word = '0;
      PAT_ONES:  pat_word = '1;
      PAT_ALT:   pat_word = alt_ph ? odd_mask : even_mask;
      PAT_RAMP:  pat_word = ramp_q;
      PAT_USER:  pat_word = user_word;
      default: begin
        pat_word   = '0;
        pat_active = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fmt_lane_map.sv
module fmt_lane_map #(
  parameter int DW = 14
) (
  input  logic          phase_hi,
  input  logic          ddr_en,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] pins
);
  localparam int LANES = DW / 2;

  logic [LANES-1:0] ddr_lanes;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign ddr_lanes[l] = phase_hi ? word[2*l] : word[2*l+1];
  end

  assign pins = ddr_en ? {{(DW-LANES){1'b0}}, ddr_lanes} : word;
endmodule

// File: rtl/adc_out_formatter.sv
module adc_out_formatter
  import adc_fmt_pkg::*;
#(
  parameter int DW = 14,
  parameter int OW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_sample,
  input  logic [OW-1:0]   in_offset,
  input  logic [SELW-1:0] pat_sel,
  input  logic [DW-1:0]   pat_user,
  input  logic            ddr_mode,
  output logic [DW-1:0]   out_pins,
  output logic            out_dav
);
  logic          accept;
  logic [DW-1:0] sum;
  logic [DW-1:0] pat_word;
  logic          pat_active;
  logic [DW-1:0] word_q;
  logic          dav_q;

  assign in_ready = 1'b1;
  assign accept   = in_valid;

  fmt_offset_sat #(.DW(DW), .OW(OW)) u_off (
    .sample (in_sample),
    .offset (in_offset),
    .sum    (sum)
  );

  fmt_pattern_gen #(.DW(DW)) u_pat (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (accept),
    .sel        (pat_sel),
    .user_word  (pat_user),
    .pat_word   (pat_word),
    .pat_active (pat_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      dav_q  <= 1'b0;
    end else if (accept) begin
      word_q <= pat_active ? pat_word : sum;
      dav_q  <= ~dav_q;
    end
  end

  fmt_lane_map #(.DW(DW)) u_map (
    .phase_hi (clk),
    .ddr_en   (ddr_mode),
    .word     (word_q),
    .pins     (out_pins)
  );

  assign out_dav = dav_q;
endmodule

// File: rtl/adc_out_formatter_chk.sv
module adc_out_formatter_chk #(
  parameter int DW = 14,
  parameter int OW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_sample,
  input logic [OW-1:0] in_offset,
  input logic [2:0]    pat_sel,
  input logic [DW-1:0] pat_user,
  input logic          ddr_mode,
  input logic [DW-1:0] out_pins,
  input logic          out_dav
);
  localparam int LANES = DW / 2;

  // R11
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == 1'b1);

  // R10
  dav_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_dav != $past(out_dav));

  // R10
  dav_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_dav));

  // R1
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pat_sel == 3'd0 && in_offset == '0) |=>
      (ddr_mode || out_pins == $past(in_sample)));

  // R3
  zero_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pat_sel == 3'd1) |=> out_pins == '0);

  // R6
  user_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pat_sel == 3'd5) |=> (ddr_mode || out_pins == $past(pat_user)));

  // R9
  ddr_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_mode |-> out_pins[DW-1:LANES] == '0);
endmodule

bind adc_out_formatter adc_out_formatter_chk #(.DW(DW), .OW(OW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sample (in_sample),
  .in_offset (in_offset),
  .pat_sel   (pat_sel),
  .pat_user  (pat_user),
  .ddr_mode  (ddr_mode),
  .out_pins  (out_pins),
  .out_dav   (out_dav)
);

// File: tb/adc_out_formatter_bench.sv
module adc_out_formatter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [13:0] in_sample = '0;
  logic [5:0]  in_offset = '0;
  logic [2:0]  pat_sel = '0;
  logic [13:0] pat_user = '0;
  logic        ddr_mode = 1'b0;
  logic [13:0] out_pins;
  logic        out_dav;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // expected-state model
  logic [13:0] m_word = '0;
  logic        m_dav = 1'b0;
  bit          m_alt = 1'b0;
  logic [13:0] m_ramp = '0;
  int unsigned lcg = 32'h1234_5678;

  always #10 clk = ~clk;

  adc_out_formatter u_adc_out_formatter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .in_offset(in_offset), .pat_sel(pat_sel),
    .pat_user(pat_user), .ddr_mode(ddr_mode), .out_pins(out_pins),
    .out_dav(out_dav)
  );

  task automatic chk(input string req, input logic [13:0] got, input logic [13:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%04h exp=0x%04h sel=%0d mode=%0d t=%0t",
               req, got, exp, pat_sel, ddr_mode, $time);
    end
  endtask

  function automatic logic [13:0] pins_exp(logic [13:0] w, logic md, bit hi);
    logic [13:0] r = '0;
    if (!md) return w;
    for (int i = 0; i < 7; i++) r[i] = hi ? w[2*i] : w[2*i+1];
    return r;
  endfunction

  function automatic string tag_of(logic [2:0] sel, int off, logic md);
    if (md) return "R9";
    case (sel)
      3'd1, 3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6, 3'd7: return "R7";
      default: return (off == 0) ? "R1/R8" : "R2/R8";
    endcase
  endfunction

  function automatic logic [13:0] sat_sum(int s, int o);
    int t = s + o;
    if (t > 8191) t = 8191;
    if (t < -8192) t = -8192;
    return t[13:0];
  endfunction

  // one sample cycle: drive, take the edge, check both clock phases
  task automatic step(input bit v, input int s, input int o, input logic [2:0] sel,
                      input logic md, input logic [13:0] usr);
    string tg;
    in_valid  = v;
    in_sample = s[13:0];
    in_offset = o[5:0];
    pat_sel   = sel;
    ddr_mode  = md;
    pat_user  = usr;
    @(posedge clk);
    if (v) begin
      case (sel)
        3'd1: m_word = 14'h0000;
        3'd2: m_word = 14'h3FFF;
        3'd3: m_word = m_alt ? 14'h2AAA : 14'h1555;
        3'd4: m_word = m_ramp;
        3'd5: m_word = usr;
        default: m_word = sat_sum(s, o);
      endcase
      m_alt  = (sel == 3'd3) ? !m_alt : 1'b0;
      m_ramp = (sel == 3'd4) ? m_ramp + 14'd1 : 14'd0;
      m_dav  = !m_dav;
    end
    tg = v ? tag_of(sel, o, md) : "R10";
    #5;
    chk(tg, out_pins, pins_exp(m_word, md, 1'b1));
    chk("R10", {13'b0, out_dav}, {13'b0, m_dav});
    #10;
    chk(tg, out_pins, pins_exp(m_word, md, 1'b0));
    #1;
  endtask

  function automatic int rnd_sample();
    lcg = lcg * 1103515245 + 12345;
    return int'(lcg[29:16]) - 8192;
  endfunction

  initial begin
    int n = 0;
    #14;
    chk("R10", out_pins, 14'h0);
    chk("R10", {13'b0, out_dav}, 14'h0);
    chk("R11", {13'b0, in_ready}, 14'h1);
    #22 rst_n = 1'b1;
    @(posedge clk);
    #16;
    // R1 R2 R8 R9 R10: every offset against a spread of samples incl. limits
    for (int o = -32; o <= 31; o++) begin
      for (int k = 0; k < 174; k++) begin
        int s;
        if (k < 170) s = -8192 + k * 96;
        else if (k == 170) s = -8192;
        else if (k == 171) s = -8191;
        else if (k == 172) s = 8191;
        else s = 8190;
        n++;
        step((n % 13) != 0, s, o, 3'd0, logic'(o[0]), 14'h0);
      end
    end
    // R3..R7 with both mappings, sample and offset varied to show no effect
    for (int sel = 1; sel < 8; sel++) begin
      for (int md = 0; md < 2; md++) begin
        for (int k = 0; k < 40; k++) begin
          int o;
          o = (k * 7) % 64 - 32;
          step((k % 9) != 8, rnd_sample(), o, sel[2:0], md[0], 14'(k * 611 + sel));
        end
      end
    end
    // R5: full ramp run through the wrap, then leave and re-enter
    for (int k = 0; k < 16390; k++)
      step(1'b1, rnd_sample(), 5, 3'd4, 1'b0, 14'h0);
    step(1'b1, 100, 0, 3'd0, 1'b0, 14'h0);
    for (int k = 0; k < 4; k++)
      step(1'b1, 100, 0, 3'd4, 1'b0, 14'h0);
    // R4: restart after leaving the alternating pattern
    step(1'b1, 0, 0, 3'd3, 1'b1, 14'h0);
    step(1'b1, 0, 0, 3'd2, 1'b1, 14'h0);
    step(1'b1, 0, 0, 3'd3, 1'b0, 14'h0);
    step(1'b1, 0, 0, 3'd3, 1'b0, 14'h0);
    chk("R11", {13'b0, in_ready}, 14'h1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd190000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule